// File: doc/BRIEF.md
# Speculatively indexed, physically tagged L1 lookup unit

This unit is the lookup path of a small set-associative first-level data cache whose set index is wider than the untranslated part of an address. Pages are 4 KiB and lines 64 bytes, so virtual address bits [11:6] select the set directly. The remaining index bits lie above the page offset and would normally have to wait for translation. Instead, the unit guesses them and reads every way of the guessed set while the physical page number is still being fetched. Tags hold physical page bits and are always compared with the translated page number.

When translation returns, the guessed bits are compared with the low bits of the physical page number. If they agree, the tag compare on the set already read decides hit or true miss. If they disagree, the unit reads the array a second time using the correct set and answers one cycle later. The guess comes from a small direct-mapped table indexed by the low bits of the load tag. It remembers the last physical bits seen for that tag. An empty entry falls back to the virtual address bits at the same positions.

A fill port installs lines at a physical address and picks the victim way round-robin within the set. Three counters record hits, true misses and mispredicted indices. The unit handles one lookup at a time, so responses come back in request order.

Top module: `sipt_cache`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `xlat_req` are 0, and all three counters are 0.
- R2: On acceptance the set read is {predicted bits, `req_vaddr[11:6]`}. `xlat_req` is high with `xlat_vpn` = `req_vaddr[23:12]` from the cycle after acceptance until translation returns. When the prediction equals `xlat_ppn[1:0]`, the response is valid in the cycle after the cycle in which `xlat_valid` is high.
- R3: A way hits only when it holds a valid line and its stored tag equals `xlat_ppn[11:2]`. Virtual page bits play no part in the compare, and the response carries that way's data.
- R4: When the predicted bits differ from `xlat_ppn[1:0]`, the set {`xlat_ppn[1:0]`, `vaddr[11:6]`} is read again. The response arrives one cycle later than in R2, with `rsp_replayed` = 1 and the hit, miss and data outcome of the correct set.
- R5: A tag miss with correctly predicted bits gives `rsp_miss` = 1, `rsp_hit` = 0, `rsp_replayed` = 0 and `rsp_data` = 0. Exactly one of hit and miss is high on every response.
- R6: The prediction is the entry at `req_ltag[3:0]` when that entry is filled. Otherwise it is `req_vaddr[13:12]`. Every completed access writes `xlat_ppn[1:0]` into the entry for its load tag.
- R7: `req_ready` is 0 from the cycle after acceptance until the response cycle, including while a replay is pending. Each response is valid for one cycle.
- R8: `cnt_hit`, `cnt_miss` and `cnt_mispred` each increase by one in the same cycle as a response that is a hit, a miss, or replayed, respectively.
- R9: A fill writes the line into set `fill_paddr[13:6]` with tag `fill_paddr[23:14]`. The victim way rotates 0, 1, 0, ... separately for each set, so the third fill to a set evicts the first.
- R10: `rsp_ltag` returns the load tag of the request being answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Unit can accept a lookup |
| req_vaddr | input | 24 | Virtual byte address |
| req_ltag | input | 6 | Load tag |
| xlat_req | output | 1 | Translation wanted for `xlat_vpn` |
| xlat_vpn | output | 12 | Virtual page number being translated |
| xlat_valid | input | 1 | Translation result present (one cycle) |
| xlat_ppn | input | 12 | Physical page number |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_hit | output | 1 | Lookup hit |
| rsp_miss | output | 1 | True miss |
| rsp_replayed | output | 1 | Index was mispredicted and the array was read again |
| rsp_data | output | 32 | Hit data, zero on a miss |
| rsp_ltag | output | 6 | Load tag of the answered request |
| fill_valid | input | 1 | Install a line |
| fill_paddr | input | 24 | Physical address of the line |
| fill_data | input | 32 | Line payload |
| cnt_hit | output | 16 | Hit count |
| cnt_miss | output | 16 | True-miss count |
| cnt_mispred | output | 16 | Mispredicted-index count |

## Verification
Every result is due a fixed number of cycles after its stimulus. `req_ready` falls and `xlat_req` rises one cycle after acceptance. A correctly guessed lookup answers one cycle after the translation cycle, and a mispredicted one answers two cycles after it. The counters step in the response cycle, and a fill becomes visible to the next lookup. The bench drives each stimulus on a falling edge and then steps one falling edge at a time. At each step it samples exactly the outputs due in that cycle and confirms that nothing arrives early. It runs directed cases (default prediction, learned prediction, replay, true miss, physical-only tag compare, round-robin eviction) and then a seeded random mix of fills and lookups with translation delays of 0 to 3 cycles. All of these are checked against a bench model of the sets, the ways and the prediction table.

// File: rtl/sipt_pkg.sv
package sipt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_REPLAY = 2'd2
  } look_st_e;
endpackage

// File: rtl/sipt_pred.sv
module sipt_pred #(
  parameter int VA_W      = 24,
  parameter int PAGE_BITS = 12,
  parameter int LTAG_W    = 6,
  parameter int IDX_W     = 4,
  parameter int PRED_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LTAG_W-1:0] lk_ltag,
  input  logic [VA_W-1:0]   lk_vaddr,
  output logic [PRED_W-1:0] lk_bits,
  input  logic              upd_en,
  input  logic [LTAG_W-1:0] upd_ltag,
  input  logic [PRED_W-1:0] upd_bits
);
  localparam int ENT = 1 << IDX_W;

  logic [ENT-1:0]    ent_vld_q;
  logic [PRED_W-1:0] ent_bits_q [ENT];
  logic [IDX_W-1:0]  lk_idx;
  logic [IDX_W-1:0]  up_idx;

  assign lk_idx = lk_ltag[IDX_W-1:0];
  assign up_idx = upd_ltag[IDX_W-1:0];

  always_comb begin
    if (ent_vld_q[lk_idx]) lk_bits = ent_bits_q[lk_idx];
    else                   lk_bits = lk_vaddr[PAGE_BITS+PRED_W-1:PAGE_BITS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ent_vld_q <= '0;
    else if (upd_en) ent_vld_q[up_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (upd_en) ent_bits_q[up_idx] <= upd_bits;
  end

  // R6: an update is visible to the next lookup of the same entry
  assert_pred_learn_R6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> (ent_vld_q[$past(up_idx)] && ent_bits_q[$past(up_idx)] == $past(upd_bits)));
endmodule

// File: rtl/sipt_store.sv
module sipt_store #(
  parameter int SET_W  = 8,
  parameter int WAYS   = 2,
  parameter int TAG_W  = 10,
  parameter int DATA_W = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd_en,
  input  logic [SET_W-1:0]             rd_set,
  output logic [WAYS-1:0]              rd_vld,
  output logic [WAYS-1:0][TAG_W-1:0]   rd_tag,
  output logic [WAYS-1:0][DATA_W-1:0]  rd_data,
  input  logic                         fill_en,
  input  logic [SET_W-1:0]             fill_set,
  input  logic [TAG_W-1:0]             fill_tag,
  input  logic [DATA_W-1:0]            fill_data
);
  localparam int SETS  = 1 << SET_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [WAYS-1:0]   vld_q  [SETS];
  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [DATA_W-1:0] data_q [SETS][WAYS];
  logic [WAY_W-1:0]  rr_q   [SETS];
  logic [WAY_W-1:0]  victim;
  logic [WAY_W-1:0]  victim_nx;

  assign victim    = rr_q[fill_set];
  assign victim_nx = (victim == WAY_W'(WAYS-1)) ? '0 : victim + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        rr_q[s]  <= '0;
      end
    end else if (fill_en) begin
      vld_q[fill_set][victim] <= 1'b1;
      rr_q[fill_set]          <= victim_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_set][victim]  <= fill_tag;
      data_q[fill_set][victim] <= fill_data;
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way_rd
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_vld[w] <= 1'b0;
      else if (rd_en) rd_vld[w] <= vld_q[rd_set][w];
    end
    always_ff @(posedge clk) begin
      if (rd_en) begin
        rd_tag[w]  <= tag_q[rd_set][w];
        rd_data[w] <= data_q[rd_set][w];
      end
    end
  end

  // R9: the chosen victim becomes valid and the pointer moves on
  assert_fill_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> vld_q[$past(fill_set)][$past(victim)]);
  assert_rr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (rr_q[$past(fill_set)] != $past(victim)));
endmodule

// File: rtl/sipt_ctrl.sv
module sipt_ctrl
  import sipt_pkg::*;
#(
  parameter int VA_W      = 24,
  parameter int PPN_W     = 12,
  parameter int PAGE_BITS = 12,
  parameter int LINE_BITS = 6,
  parameter int PRED_W    = 2,
  parameter int WAYS      = 2,
  parameter int LTAG_W    = 6,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 16,
  parameter int SET_W     = PAGE_BITS - LINE_BITS + PRED_W,
  parameter int TAG_W     = PPN_W - PRED_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [VA_W-1:0]              req_vaddr,
  input  logic [LTAG_W-1:0]            req_ltag,
  input  logic [PRED_W-1:0]            pred_bits,
  output logic                         xlat_req,
  output logic [VA_W-PAGE_BITS-1:0]    xlat_vpn,
  input  logic                         xlat_valid,
  input  logic [PPN_W-1:0]             xlat_ppn,
  output logic                         rd_en,
  output logic [SET_W-1:0]             rd_set,
  input  logic [WAYS-1:0]              rd_vld,
  input  logic [WAYS-1:0][TAG_W-1:0]   rd_tag,
  input  logic [WAYS-1:0][DATA_W-1:0]  rd_data,
  output logic                         upd_en,
  output logic [LTAG_W-1:0]            upd_ltag,
  output logic [PRED_W-1:0]            upd_bits,
  output logic                         rsp_valid,
  output logic                         rsp_hit,
  output logic                         rsp_miss,
  output logic                         rsp_replayed,
  output logic [DATA_W-1:0]            rsp_data,
  output logic [LTAG_W-1:0]            rsp_ltag,
  output logic [CNT_W-1:0]             cnt_hit,
  output logic [CNT_W-1:0]             cnt_miss,
  output logic [CNT_W-1:0]             cnt_mispred
);
  localparam int LOW_W = PAGE_BITS - LINE_BITS;

  look_st_e          st_q, st_d;
  logic [VA_W-1:0]   va_q, va_d;
  logic [LTAG_W-1:0] ltag_q, ltag_d;
  logic [PRED_W-1:0] pbits_q, pbits_d;
  logic [PPN_W-1:0]  ppn_q, ppn_d;
  logic              rv_q, rv_d, rh_q, rh_d, rm_q, rm_d, rr_q, rr_d;
  logic [DATA_W-1:0] rdat_q, rdat_d;
  logic [LTAG_W-1:0] rlt_q, rlt_d;
  logic [CNT_W-1:0]  ch_q, ch_d, cm_q, cm_d, cp_q, cp_d;

  logic              accept, mispred, resolve;
  logic [PPN_W-1:0]  cmp_ppn;
  logic [PRED_W-1:0] true_bits;
  logic [WAYS-1:0]   way_hit;
  logic [DATA_W-1:0] hit_data;

  assign accept    = (st_q == ST_IDLE) && req_valid;
  assign cmp_ppn   = (st_q == ST_REPLAY) ? ppn_q : xlat_ppn;
  assign true_bits = cmp_ppn[PRED_W-1:0];
  assign mispred   = (st_q == ST_WAIT) && xlat_valid && (true_bits != pbits_q);
  assign resolve   = ((st_q == ST_WAIT) && xlat_valid && (true_bits == pbits_q)) ||
                     (st_q == ST_REPLAY);

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign way_hit[w] = rd_vld[w] && (rd_tag[w] == cmp_ppn[PPN_W-1:PRED_W]);
  end

  always_comb begin
    hit_data = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_hit[w]) hit_data = hit_data | rd_data[w];
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign xlat_req  = (st_q == ST_WAIT);
  assign xlat_vpn  = va_q[VA_W-1:PAGE_BITS];
  assign rd_en     = accept || mispred;
  assign rd_set    = accept ? {pred_bits, req_vaddr[PAGE_BITS-1:LINE_BITS]}
                            : {true_bits, va_q[PAGE_BITS-1:LINE_BITS]};
  assign upd_en    = resolve;
  assign upd_ltag  = ltag_q;
  assign upd_bits  = true_bits;

  always_comb begin
    st_d    = st_q;
    va_d    = va_q;
    ltag_d  = ltag_q;
    pbits_d = pbits_q;
    ppn_d   = ppn_q;
    rv_d    = 1'b0;
    rh_d    = rh_q;
    rm_d    = rm_q;
    rr_d    = rr_q;
    rdat_d  = rdat_q;
    rlt_d   = rlt_q;
    ch_d    = ch_q;
    cm_d    = cm_q;
    cp_d    = cp_q;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          va_d    = req_vaddr;
          ltag_d  = req_ltag;
          pbits_d = pred_bits;
          st_d    = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (mispred) begin
          ppn_d = xlat_ppn;
          st_d  = ST_REPLAY;
        end
      end
      ST_REPLAY: ;
      default: st_d = ST_IDLE;
    endcase
    if (resolve) begin
      st_d   = ST_IDLE;
      rv_d   = 1'b1;
      rh_d   = |way_hit;
      rm_d   = ~(|way_hit);
      rr_d   = (st_q == ST_REPLAY);
      rdat_d = hit_data;
      rlt_d  = ltag_q;
      if (|way_hit) ch_d = ch_q + 1'b1;
      else          cm_d = cm_q + 1'b1;
      if (st_q == ST_REPLAY) cp_d = cp_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      rv_q   <= 1'b0;
      rh_q   <= 1'b0;
      rm_q   <= 1'b0;
      rr_q   <= 1'b0;
      rdat_q <= '0;
      rlt_q  <= '0;
      ch_q   <= '0;
      cm_q   <= '0;
      cp_q   <= '0;
    end else begin
      st_q   <= st_d;
      rv_q   <= rv_d;
      rh_q   <= rh_d;
      rm_q   <= rm_d;
      rr_q   <= rr_d;
      rdat_q <= rdat_d;
      rlt_q  <= rlt_d;
      ch_q   <= ch_d;
      cm_q   <= cm_d;
      cp_q   <= cp_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      va_q    <= va_d;
      ltag_q  <= ltag_d;
      pbits_q <= pbits_d;
    end
    if (mispred) ppn_q <= ppn_d;
  end

  assign rsp_valid    = rv_q;
  assign rsp_hit      = rh_q;
  assign rsp_miss     = rm_q;
  assign rsp_replayed = rr_q;
  assign rsp_data     = rdat_q;
  assign rsp_ltag     = rlt_q;
  assign cnt_hit      = ch_q;
  assign cnt_miss     = cm_q;
  assign cnt_mispred  = cp_q;

  // R5: a response is either a hit or a miss, never both
  assert_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit != rsp_miss));
  // R7: one-cycle response, never back to back
  assert_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R2: a direct response follows the translation-wait state
  assert_direct_lat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_replayed) |-> ($past(st_q) == ST_WAIT));
  // R4: a replayed response follows exactly one replay cycle
  assert_replay_lat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_replayed) |-> ($past(st_q) == ST_REPLAY && !$past(req_ready)));
  // R8: counters move only with a matching response
  assert_cnt_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_hit) |-> (rsp_valid && rsp_hit));
  assert_cnt_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_miss) |-> (rsp_valid && rsp_miss));
  assert_cnt_mp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_mispred) |-> (rsp_valid && rsp_replayed));
endmodule

// File: rtl/sipt_cache.sv
module sipt_cache #(
  parameter int VA_W      = 24,
  parameter int PPN_W     = 12,
  parameter int PAGE_BITS = 12,
  parameter int LINE_BITS = 6,
  parameter int PRED_W    = 2,
  parameter int WAYS      = 2,
  parameter int LTAG_W    = 6,
  parameter int PT_IDX_W  = 4,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [VA_W-1:0]            req_vaddr,
  input  logic [LTAG_W-1:0]          req_ltag,
  output logic                       xlat_req,
  output logic [VA_W-PAGE_BITS-1:0]  xlat_vpn,
  input  logic                       xlat_valid,
  input  logic [PPN_W-1:0]           xlat_ppn,
  output logic                       rsp_valid,
  output logic                       rsp_hit,
  output logic                       rsp_miss,
  output logic                       rsp_replayed,
  output logic [DATA_W-1:0]          rsp_data,
  output logic [LTAG_W-1:0]          rsp_ltag,
  input  logic                       fill_valid,
  input  logic [PPN_W+PAGE_BITS-1:0] fill_paddr,
  input  logic [DATA_W-1:0]          fill_data,
  output logic [CNT_W-1:0]           cnt_hit,
  output logic [CNT_W-1:0]           cnt_miss,
  output logic [CNT_W-1:0]           cnt_mispred
);
  localparam int SET_W = PAGE_BITS - LINE_BITS + PRED_W;
  localparam int TAG_W = PPN_W - PRED_W;
  localparam int PA_W  = PPN_W + PAGE_BITS;

  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic [PRED_W-1:0]            pred_bits;
  logic                         rd_en;
  logic [SET_W-1:0]             rd_set;
  logic [WAYS-1:0]              rd_vld;
  logic [WAYS-1:0][TAG_W-1:0]   rd_tag;
  logic [WAYS-1:0][DATA_W-1:0]  rd_data;
  logic                         upd_en;
  logic [LTAG_W-1:0]            upd_ltag;
  logic [PRED_W-1:0]            upd_bits;

  sipt_pred #(
    .VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .LTAG_W(LTAG_W),
    .IDX_W(PT_IDX_W), .PRED_W(PRED_W)
  ) pred_i (
    .clk(clk), .rst_n(rst_n_int),
    .lk_ltag(req_ltag), .lk_vaddr(req_vaddr), .lk_bits(pred_bits),
    .upd_en(upd_en), .upd_ltag(upd_ltag), .upd_bits(upd_bits)
  );

  sipt_store #(
    .SET_W(SET_W), .WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) store_i (
    .clk(clk), .rst_n(rst_n_int),
    .rd_en(rd_en), .rd_set(rd_set),
    .rd_vld(rd_vld), .rd_tag(rd_tag), .rd_data(rd_data),
    .fill_en(fill_valid),
    .fill_set(fill_paddr[LINE_BITS+SET_W-1:LINE_BITS]),
    .fill_tag(fill_paddr[PA_W-1:LINE_BITS+SET_W]),
    .fill_data(fill_data)
  );

  sipt_ctrl #(
    .VA_W(VA_W), .PPN_W(PPN_W), .PAGE_BITS(PAGE_BITS), .LINE_BITS(LINE_BITS),
    .PRED_W(PRED_W), .WAYS(WAYS), .LTAG_W(LTAG_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n_int),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_ltag(req_ltag), .pred_bits(pred_bits),
    .xlat_req(xlat_req), .xlat_vpn(xlat_vpn),
    .xlat_valid(xlat_valid), .xlat_ppn(xlat_ppn),
    .rd_en(rd_en), .rd_set(rd_set),
    .rd_vld(rd_vld), .rd_tag(rd_tag), .rd_data(rd_data),
    .upd_en(upd_en), .upd_ltag(upd_ltag), .upd_bits(upd_bits),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_replayed(rsp_replayed), .rsp_data(rsp_data), .rsp_ltag(rsp_ltag),
    .cnt_hit(cnt_hit), .cnt_miss(cnt_miss), .cnt_mispred(cnt_mispred)
  );
endmodule

// File: tb/sipt_cache_tb.sv
module sipt_cache_tb_top;
  localparam int NSETS = 256;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [23:0] req_vaddr;
  logic [5:0]  req_ltag;
  logic        xlat_req;
  logic [11:0] xlat_vpn;
  logic        xlat_valid;
  logic [11:0] xlat_ppn;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_replayed;
  logic [31:0] rsp_data;
  logic [5:0]  rsp_ltag;
  logic        fill_valid;
  logic [23:0] fill_paddr;
  logic [31:0] fill_data;
  logic [15:0] cnt_hit, cnt_miss, cnt_mispred;

  always #4 clk = ~clk;

  sipt_cache dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_ltag(req_ltag),
    .xlat_req(xlat_req), .xlat_vpn(xlat_vpn),
    .xlat_valid(xlat_valid), .xlat_ppn(xlat_ppn),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_replayed(rsp_replayed), .rsp_data(rsp_data), .rsp_ltag(rsp_ltag),
    .fill_valid(fill_valid), .fill_paddr(fill_paddr), .fill_data(fill_data),
    .cnt_hit(cnt_hit), .cnt_miss(cnt_miss), .cnt_mispred(cnt_mispred)
  );

  int checks = 0;
  int errors = 0;

  logic        m_vld  [NSETS][2];
  logic [9:0]  m_tag  [NSETS][2];
  logic [31:0] m_data [NSETS][2];
  int          m_rr   [NSETS];
  logic        p_vld  [16];
  logic [1:0]  p_bits [16];
  int e_hit = 0, e_miss = 0, e_mp = 0;

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_pred(input logic [23:0] va, input logic [5:0] lt);
    if (p_vld[lt[3:0]]) return p_bits[lt[3:0]];
    return va[13:12];
  endfunction

  function automatic int find_way(input int set, input logic [9:0] tag);
    for (int w = 0; w < 2; w++) if (m_vld[set][w] && m_tag[set][w] == tag) return w;
    return -1;
  endfunction

  task automatic do_fill(input logic [23:0] pa, input logic [31:0] d);
    int set;
    set = int'(pa[13:6]);
    @(negedge clk);
    fill_valid = 1'b1; fill_paddr = pa; fill_data = d;
    @(negedge clk);
    fill_valid = 1'b0;
    m_vld[set][m_rr[set]]  = 1'b1;
    m_tag[set][m_rr[set]]  = pa[23:14];
    m_data[set][m_rr[set]] = d;
    m_rr[set] = (m_rr[set] + 1) % 2;
  endtask

  task automatic do_access(input logic [23:0] va, input logic [5:0] lt,
                           input logic [11:0] ppn, input int dly);
    logic mis;
    int   set, w;
    mis = (exp_pred(va, lt) != ppn[1:0]);
    set = int'({ppn[1:0], va[11:6]});
    w   = find_way(set, ppn[11:2]);
    @(negedge clk);
    chk("R7 ready before request", req_ready, 1);
    req_valid = 1'b1; req_vaddr = va; req_ltag = lt;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7 ready low after accept", req_ready, 0);
    chk("R2 xlat_req", xlat_req, 1);
    chk("R2 xlat_vpn", xlat_vpn, va[23:12]);
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      chk("R7 no early response", rsp_valid, 0);
    end
    xlat_valid = 1'b1; xlat_ppn = ppn;
    @(negedge clk);
    xlat_valid = 1'b0;
    if (mis) begin
      chk("R4 replay adds a cycle", rsp_valid, 0);
      chk("R7 ready low during replay", req_ready, 0);
      @(negedge clk);
    end
    chk(mis ? "R4 response valid" : "R2 response valid", rsp_valid, 1);
    chk(mis ? "R4 replayed flag" : "R5 replayed flag", rsp_replayed, mis);
    chk("R3 hit", rsp_hit, w >= 0);
    chk("R5 miss", rsp_miss, w < 0);
    chk("R3 data", rsp_data, (w >= 0) ? m_data[set][w] : 32'h0);
    chk("R10 ltag echo", rsp_ltag, lt);
    if (w >= 0) e_hit++; else e_miss++;
    if (mis) e_mp++;
    chk("R8 hit count", cnt_hit, e_hit);
    chk("R8 miss count", cnt_miss, e_miss);
    chk("R8 mispredict count", cnt_mispred, e_mp);
    p_vld[lt[3:0]]  = 1'b1;
    p_bits[lt[3:0]] = ppn[1:0];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int s = 0; s < NSETS; s++) begin
      m_rr[s] = 0;
      for (int w = 0; w < 2; w++) m_vld[s][w] = 1'b0;
    end
    for (int i = 0; i < 16; i++) p_vld[i] = 1'b0;
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_ltag = '0;
    xlat_valid = 1'b0; xlat_ppn = '0;
    fill_valid = 1'b0; fill_paddr = '0; fill_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 ready", req_ready, 1);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 xlat_req", xlat_req, 0);
    chk("R1 counters", {cnt_hit, cnt_miss, cnt_mispred}, 0);

    // R2/R6: empty entry takes VA[13:12]=11, matches PPN low bits
    do_fill({12'h123, 6'h05, 6'h00}, 32'hA5A5_0001);
    do_access({10'h3F0, 2'b11, 6'h05, 6'h08}, 6'd1, 12'h123, 0);
    chk("R6 default prediction correct", rsp_replayed, 0);
    // R6: learned entry predicts 11 although VA bits are 00
    do_access({10'h001, 2'b00, 6'h05, 6'h00}, 6'd1, 12'h123, 2);
    chk("R6 learned prediction", rsp_replayed, 0);
    // R4: new tag, VA bits 00 wrong, replay finds the line
    do_access({10'h002, 2'b00, 6'h05, 6'h00}, 6'd2, 12'h123, 1);
    chk("R4 replay hit", rsp_hit, 1);
    // R5: correct bits, different physical tag
    do_access({10'h003, 2'b00, 6'h05, 6'h00}, 6'd1, 12'h127, 0);
    chk("R5 true miss", rsp_miss, 1);
    // R3: VA page equals stored tag, PA does not
    do_fill({12'h456, 6'h09, 6'h00}, 32'h0000_BEEF);
    do_access({12'h456, 6'h09, 6'h00}, 6'd3, 12'h55E, 0);
    chk("R3 physical-only compare", rsp_hit, 0);
    // R9: third fill to one set evicts the first
    do_fill({12'h10B, 6'h20, 6'h00}, 32'h1111_1111);
    do_fill({12'h20B, 6'h20, 6'h00}, 32'h2222_2222);
    do_fill({12'h30B, 6'h20, 6'h00}, 32'h3333_3333);
    do_access({10'h10B >> 2, 2'b11, 6'h20, 6'h00}, 6'd4, 12'h10B, 0);
    chk("R9 oldest evicted", rsp_miss, 1);
    do_access({10'h0, 2'b11, 6'h20, 6'h00}, 6'd4, 12'h20B, 1);
    chk("R9 second kept", rsp_hit, 1);
    do_access({10'h0, 2'b11, 6'h20, 6'h00}, 6'd4, 12'h30B, 0);
    chk("R9 newest present", rsp_hit, 1);

    for (int n = 0; n < 500; n++) begin
      logic [11:0] ppn;
      logic [5:0]  lo;
      ppn = {8'($urandom % 4) + 8'h40, 2'($urandom)};
      lo  = 6'($urandom % 4) + 6'h30;
      if ($urandom % 10 < 4) begin
        if (find_way(int'({ppn[1:0], lo}), ppn[11:2]) < 0)
          do_fill({ppn, lo, 6'h00}, $urandom);
      end else begin
        do_access({10'($urandom), 2'($urandom), lo, 6'($urandom)},
                  6'($urandom), ppn, int'($urandom % 4));
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule